// File: doc/BRIEF.md
# Serial Debug Register Port

This block gives an external debug master bit-serial access to a small bank of internal registers. The master picks a register with a 3-bit number, then moves data one bit per shift-clock pulse. Selection happens in an address phase: the select input is low, the address-mode line is high, and the number goes in most-significant bit first. Data moves while select is high, also most-significant bit first, through one shared shift path whatever the width of the register.

Register 0 is a fixed 16-bit identification word, 0x5180. It can be read at once, because its first bit is already on serial-out when select rises. Any other register must be captured into the shift path first. The master does this by giving one shift-clock pulse with execute held high. Register 1 is a 10-bit writable control word, driven out on a port. Register 2 (32 bits) and register 3 (12 bits) are read-only snapshots of status inputs. The active-low reset and freeze lines on the control bus are only decoded into active-high request outputs.

All control lines are registered into the system clock domain. A shift-clock edge is found by comparing the registered shift clock with a second, delayed copy. A state change therefore follows a rising shift clock by two system clocks.

Top module: `dbg_serial_port`

## Requirements
- R1: After system reset, serial-out is low, the control word is 0, the selected register is 0, and raising select shows the identification word without any address phase.
- R2: Each rising shift clock with address mode high and select low shifts serial-in into a 3-bit register number, most-significant bit first. With select high, address-mode pulses leave the number unchanged.
- R3: Register 0 reads back as the 16-bit value 0x5180, most-significant bit first, with no execute step. Its first bit is on serial-out before any data shift clock.
- R4: A write to register 1 takes 10 serial-in bits, most-significant first, one per rising shift clock with select high and execute low. The word is updated on the 10th pulse.
- R5: A shift clock with select and execute high copies the selected register into the shift path. Later changes to the status inputs do not alter the bits shifted out.
- R6: After capture, serial-out presents bit width-1 first and the next lower bit after each following shift clock. The widths are 10, 32 and 12 for registers 1, 2 and 3.
- R7: A read of register 1 (width-1 pulses) leaves it unchanged. Shifting 16 or 32 bits into register 0 or register 2 has no effect on what they read back.
- R8: Fewer than 10 data pulses followed by select going low leave register 1 unchanged.
- R9: Serial-out is held low while select is low, even when the shift path holds a one.
- R10: The reset and freeze request outputs are the inverse of the active-low control lines, one system clock after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| dbg_sel | input | 1 | Data phase select |
| dbg_sdi | input | 1 | Serial data / address in |
| dbg_reset_n | input | 1 | Active-low reset line of the control bus |
| dbg_freeze_n | input | 1 | Active-low freeze line of the control bus |
| dbg_exec | input | 1 | Capture request for reads |
| dbg_addr_mode | input | 1 | Address phase enable |
| dbg_sck | input | 1 | Shift clock, sampled by clk |
| stat_wide_i | input | 32 | Status word behind register 2 |
| stat_narrow_i | input | 12 | Status word behind register 3 |
| dbg_sdo | output | 1 | Serial data out |
| ctrl_q | output | 10 | Register 1 contents |
| dbg_reset_req | output | 1 | Decoded reset request |
| dbg_freeze_req | output | 1 | Decoded freeze request |

## Verification
The bench drives random 10-bit control words and random 32-bit and 12-bit status words through full write, capture and read sequences. This shows the bit order and the per-register width apart from one another. Directed cases cover the points where a wrong design differs from a correct one:
- reading the identification word right after reset, with no address phase;
- a status input changing after capture;
- a write cut short by dropping select;
- address-mode pulses while select is high;
- writes aimed at read-only registers;
- serial-out while select is low with a one in the path.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned PATH_W   = 32;
  localparam int unsigned CNT_W    = $clog2(PATH_W + 1);
  localparam int unsigned ID_W     = 16;
  localparam int unsigned CTRL_W   = 10;
  localparam int unsigned WIDE_W   = 32;
  localparam int unsigned NARROW_W = 12;

  typedef struct packed {
    logic sel;
    logic sdi;
    logic reset_n;
    logic freeze_n;
    logic exec;
    logic amode;
    logic sck;
  } dsp_lines_t;

  function automatic int unsigned reg_width(input logic [ADDR_W-1:0] a);
    case (a)
      3'd0:    reg_width = ID_W;
      3'd1:    reg_width = CTRL_W;
      3'd2:    reg_width = WIDE_W;
      3'd3:    reg_width = NARROW_W;
      default: reg_width = 1;
    endcase
  endfunction
endpackage

// File: rtl/dsp_sync.sv
module dsp_sync
  import dsp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  dsp_lines_t lines_i,
  output dsp_lines_t lines_q,
  output logic       sck_rise
);
  dsp_lines_t stage_q;
  logic       sck_dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q   <= '{sel: 1'b0, sdi: 1'b0, reset_n: 1'b1, freeze_n: 1'b1,
                     exec: 1'b0, amode: 1'b0, sck: 1'b0};
      sck_dly_q <= 1'b0;
    end else begin
      stage_q   <= lines_i;
      sck_dly_q <= stage_q.sck;
    end
  end

  assign lines_q  = stage_q;
  assign sck_rise = stage_q.sck & ~sck_dly_q;
endmodule

// File: rtl/dsp_addr.sv
module dsp_addr
  import dsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  dsp_lines_t        lines_q,
  input  logic              sck_rise,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] addr_nxt,
  output logic              addr_shift
);
  logic [ADDR_W-1:0] addr_d;

  assign addr_shift = sck_rise & lines_q.amode & ~lines_q.sel;
  assign addr_nxt   = {addr_q[ADDR_W-2:0], lines_q.sdi};

  always_comb begin
    addr_d = addr_q;
    if (addr_shift) addr_d = addr_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end
endmodule

// File: rtl/dsp_shift.sv
module dsp_shift
  import dsp_pkg::*;
#(
  parameter logic [ID_W-1:0] ID_VALUE = 16'h5180
) (
  input  logic                clk,
  input  logic                rst_n,
  input  dsp_lines_t          lines_q,
  input  logic                sck_rise,
  input  logic [ADDR_W-1:0]   addr_q,
  input  logic [ADDR_W-1:0]   addr_nxt,
  input  logic                addr_shift,
  input  logic [WIDE_W-1:0]   stat_wide_i,
  input  logic [NARROW_W-1:0] stat_narrow_i,
  output logic                sdo,
  output logic [CTRL_W-1:0]   ctrl_q,
  output logic [CNT_W-1:0]    cnt_q
);
  logic [PATH_W-1:0] path_q, path_d;
  logic [CTRL_W-1:0] ctrl_d;
  logic [CNT_W-1:0]  cnt_d;
  logic              data_edge, cap_edge;
  logic [PATH_W-1:0] cap_val;
  int unsigned       cur_w;

  assign data_edge = sck_rise & lines_q.sel & ~lines_q.amode;
  assign cap_edge  = data_edge & lines_q.exec;
  assign cur_w     = reg_width(addr_q);

  always_comb begin
    cap_val = '0;
    case (addr_q)
      3'd0:    cap_val[ID_W-1:0]     = ID_VALUE;
      3'd1:    cap_val[CTRL_W-1:0]   = ctrl_q;
      3'd2:    cap_val[WIDE_W-1:0]   = stat_wide_i;
      3'd3:    cap_val[NARROW_W-1:0] = stat_narrow_i;
      default: cap_val = '0;
    endcase
  end

  always_comb begin
    path_d = path_q;
    ctrl_d = ctrl_q;
    cnt_d  = cnt_q;
    if (addr_shift) begin
      cnt_d = '0;
      if (addr_nxt == '0) begin
        path_d = '0;
        path_d[ID_W-1:0] = ID_VALUE;
      end
    end else if (cap_edge) begin
      path_d = cap_val;
      cnt_d  = '0;
    end else if (data_edge) begin
      path_d = {path_q[PATH_W-2:0], lines_q.sdi};
      if (cnt_q != {CNT_W{1'b1}}) cnt_d = cnt_q + 1'b1;
      if (addr_q == 3'd1 && cnt_q == CNT_W'(CTRL_W - 1))
        ctrl_d = {path_q[CTRL_W-2:0], lines_q.sdi};
    end
    if (!lines_q.sel) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      path_q <= {{(PATH_W-ID_W){1'b0}}, ID_VALUE};
      ctrl_q <= '0;
      cnt_q  <= '0;
    end else begin
      path_q <= path_d;
      ctrl_q <= ctrl_d;
      cnt_q  <= cnt_d;
    end
  end

  assign sdo = lines_q.sel & path_q[cur_w - 1];
endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port
  import dsp_pkg::*;
#(
  parameter logic [ID_W-1:0] ID_VALUE = 16'h5180
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dbg_sel,
  input  logic                dbg_sdi,
  input  logic                dbg_reset_n,
  input  logic                dbg_freeze_n,
  input  logic                dbg_exec,
  input  logic                dbg_addr_mode,
  input  logic                dbg_sck,
  input  logic [WIDE_W-1:0]   stat_wide_i,
  input  logic [NARROW_W-1:0] stat_narrow_i,
  output logic                dbg_sdo,
  output logic [CTRL_W-1:0]   ctrl_q,
  output logic                dbg_reset_req,
  output logic                dbg_freeze_req
);
  dsp_lines_t        lines_i, lines_q;
  logic              sck_rise;
  logic [ADDR_W-1:0] addr_q, addr_nxt;
  logic              addr_shift;
  logic [CNT_W-1:0]  cnt_q;

  assign lines_i = '{sel: dbg_sel, sdi: dbg_sdi, reset_n: dbg_reset_n,
                     freeze_n: dbg_freeze_n, exec: dbg_exec,
                     amode: dbg_addr_mode, sck: dbg_sck};

  dsp_sync u_sync (
    .clk(clk), .rst_n(rst_n), .lines_i(lines_i),
    .lines_q(lines_q), .sck_rise(sck_rise)
  );

  dsp_addr u_addr (
    .clk(clk), .rst_n(rst_n), .lines_q(lines_q), .sck_rise(sck_rise),
    .addr_q(addr_q), .addr_nxt(addr_nxt), .addr_shift(addr_shift)
  );

  dsp_shift #(.ID_VALUE(ID_VALUE)) u_shift (
    .clk(clk), .rst_n(rst_n), .lines_q(lines_q), .sck_rise(sck_rise),
    .addr_q(addr_q), .addr_nxt(addr_nxt), .addr_shift(addr_shift),
    .stat_wide_i(stat_wide_i), .stat_narrow_i(stat_narrow_i),
    .sdo(dbg_sdo), .ctrl_q(ctrl_q), .cnt_q(cnt_q)
  );

  assign dbg_reset_req  = ~lines_q.reset_n;
  assign dbg_freeze_req = ~lines_q.freeze_n;
endmodule

// File: rtl/dsp_checker.sv
module dsp_checker
  import dsp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sel_s,
  input logic              exec_s,
  input logic              amode_s,
  input logic              sck_rise,
  input logic              sdo,
  input logic [ADDR_W-1:0] addr_q,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [CNT_W-1:0]  cnt_q
);
  AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_s |-> !sdo) else $error("sdo active without select"); // R9

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(sck_rise && amode_s && !sel_s) |=> $stable(addr_q)) else $error("address moved"); // R2

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(sck_rise && sel_s && !amode_s && !exec_s) |=> $stable(ctrl_q)) else $error("ctrl moved"); // R7

  AST_CTRL_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> ($past(cnt_q) == CNT_W'(CTRL_W - 1) && $past(addr_q) == 3'd1)) else $error("early commit"); // R4

  AST_CAPTURE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise && sel_s && exec_s && !amode_s) |=> cnt_q == '0) else $error("count not cleared"); // R5
endmodule

bind dbg_serial_port dsp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sel_s(lines_q.sel), .exec_s(lines_q.exec),
  .amode_s(lines_q.amode), .sck_rise(sck_rise), .sdo(dbg_sdo),
  .addr_q(addr_q), .ctrl_q(ctrl_q), .cnt_q(cnt_q)
);

// File: tb/sim_dbg_serial_port.sv
module sim_dbg_serial_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel, sdi, rn, fn, ex, am, sck;
  logic [31:0] stw;
  logic [11:0] stn;
  logic        sdo, rreq, freq;
  logic [9:0]  ctrl;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  dbg_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .dbg_sel(sel), .dbg_sdi(sdi),
    .dbg_reset_n(rn), .dbg_freeze_n(fn), .dbg_exec(ex),
    .dbg_addr_mode(am), .dbg_sck(sck), .stat_wide_i(stw),
    .stat_narrow_i(stn), .dbg_sdo(sdo), .ctrl_q(ctrl),
    .dbg_reset_req(rreq), .dbg_freeze_req(freq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int wid(input int a);
    case (a)
      0: return 16;
      1: return 10;
      2: return 32;
      3: return 12;
      default: return 1;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    sck = 1'b1; wait_n(3);
    sck = 1'b0; wait_n(3);
  endtask

  task automatic set_addr(input int a);
    sel = 1'b0; am = 1'b1; wait_n(2);
    for (int i = 2; i >= 0; i--) begin
      sdi = a[i];
      pulse();
    end
    am = 1'b0; wait_n(2);
  endtask

  task automatic capture();
    sel = 1'b1; ex = 1'b1; wait_n(2);
    pulse();
    ex = 1'b0; wait_n(2);
  endtask

  task automatic shift_out(input int w, output logic [31:0] v);
    v = '0;
    sel = 1'b1; wait_n(3);
    for (int i = w - 1; i >= 0; i--) begin
      v[i] = sdo;
      if (i > 0) pulse();
    end
    sel = 1'b0; wait_n(2);
  endtask

  task automatic read_reg(input int a, output logic [31:0] v);
    set_addr(a);
    if (a != 0) capture();
    shift_out(wid(a), v);
  endtask

  task automatic write_reg(input int a, input int nbits, input logic [31:0] v);
    set_addr(a);
    sel = 1'b1; wait_n(2);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi = v[i];
      pulse();
    end
    sel = 1'b0; wait_n(2);
  endtask

  initial begin
    wait_n(60000);
    if (!done) begin
      fails++;
      vectors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [9:0]  cw;
    void'($urandom(32'd4242));
    rst_n = 1'b0; sel = 0; sdi = 0; rn = 1; fn = 1; ex = 0; am = 0; sck = 0;
    stw = 32'h0; stn = 12'h0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);

    // R1 reset state
    check("R1 sdo", {31'd0, sdo}, 32'd0);
    check("R1 ctrl", {22'd0, ctrl}, 32'd0);
    shift_out(16, v);
    check("R1 id without addressing", v, 32'h5180);

    // R3 identification read through address phase
    read_reg(0, v);
    check("R3 id", v, 32'h5180);

    // R4 R6 random control writes read back
    for (int k = 0; k < 6; k++) begin
      cw = 10'($urandom);
      write_reg(1, 10, {22'd0, cw});
      check("R4 ctrl port", {22'd0, ctrl}, {22'd0, cw});
      read_reg(1, v);
      check("R6 ctrl readback", v, {22'd0, cw});
      // R7 read leaves it unchanged
      check("R7 ctrl after read", {22'd0, ctrl}, {22'd0, cw});
    end
    write_reg(1, 10, 32'h3FF);
    check("R4 all ones", {22'd0, ctrl}, 32'h3FF);
    write_reg(1, 10, 32'h200);
    check("R4 msb only", {22'd0, ctrl}, 32'h200);

    // R6 random status reads
    for (int k = 0; k < 6; k++) begin
      stw = $urandom; stn = 12'($urandom);
      read_reg(2, v);
      check("R6 wide", v, stw);
      read_reg(3, v);
      check("R6 narrow", v, {20'd0, stn});
    end

    // R5 capture snapshot
    stw = 32'hA5C3_0F96;
    set_addr(2);
    capture();
    stw = 32'h1234_5678;
    shift_out(32, v);
    check("R5 snapshot", v, 32'hA5C3_0F96);

    // R8 partial write dropped
    write_reg(1, 10, 32'h155);
    write_reg(1, 5, 32'h0A);
    check("R8 partial write", {22'd0, ctrl}, 32'h155);
    read_reg(1, v);
    check("R8 readback", v, 32'h155);

    // R7 writes to read-only registers
    write_reg(0, 16, 32'h0000_FFFF);
    read_reg(0, v);
    check("R7 id after write", v, 32'h5180);
    stw = 32'h0F0F_0F0F;
    write_reg(2, 32, 32'hFFFF_FFFF);
    check("R7 ctrl untouched", {22'd0, ctrl}, 32'h155);
    read_reg(2, v);
    check("R7 wide after write", v, 32'h0F0F_0F0F);

    // R2 address pulses with select high ignored
    stn = 12'h9AB;
    set_addr(3);
    sel = 1'b1; am = 1'b1; wait_n(2);
    sdi = 1'b0; pulse(); pulse(); pulse();
    am = 1'b0; wait_n(2);
    capture();
    shift_out(12, v);
    check("R2 address kept", v, 32'h9AB);

    // R9 sdo low while select low, path msb is one
    stn = 12'h800;
    set_addr(3);
    capture();
    sel = 1'b0; wait_n(3);
    check("R9 quiet", {31'd0, sdo}, 32'd0);
    sel = 1'b1; wait_n(3);
    check("R9 active", {31'd0, sdo}, 32'd1);
    sel = 1'b0; wait_n(2);

    // R10 decode
    rn = 1'b0; wait_n(2);
    check("R10 reset req", {31'd0, rreq}, 32'd1);
    check("R10 freeze idle", {31'd0, freq}, 32'd0);
    rn = 1'b1; fn = 1'b0; wait_n(2);
    check("R10 reset clear", {31'd0, rreq}, 32'd0);
    check("R10 freeze req", {31'd0, freq}, 32'd1);
    fn = 1'b1; wait_n(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule